// File: doc/BRIEF.md
# NOR Flash Page-Read Sequencer

This block runs read bursts on an asynchronous external memory bus for NOR flash parts that support page reads. A request names one of three chip selects, a starting word address and a word count. The block then drives chip select, output enable, write enable, byte mask and address. It samples the 16-bit data bus at the end of each access and returns each word with a one-cycle valid strobe.

Each chip select has its own settings: a page-read enable, a page size of 4 or 8 words, a page delay, and setup, strobe and hold counts. All of these are counted in controller clock cycles, and a programmed value N lasts N+1 cycles. The first word of a burst always takes a full setup and strobe access. While page reads are on, later words in the same page change only the address. Each of those words waits the page delay, with chip select and output enable held low. When the address crosses into a new page, the block makes a new full access. With page reads off, every word gets its own setup, strobe and hold.

A request is refused if it asks for page reads on a chip select that also has the extended-wait or select-strobe timing option set. It is also refused if it names chip select index 3 or asks for zero words. Settings are sampled when the request is taken.

Top module: `norpg_read_seq`

## Requirements
- R1: While reset is high and after it is released, the block is idle: busy=0, mem_cs_n=3'b111, mem_oe_n=1, mem_we_n=1, mem_dqm_n=2'b11, rd_valid=0, req_reject=0.
- R2: The first word of a burst follows the accepting edge by setup+1 cycles with output enable high, then strobe+1 cycles with output enable low. rd_valid is high in the cycle after edge number setup+strobe+2, counted from the accepting edge.
- R3: For the whole burst, only bit req_cs of mem_cs_n is low (index 0..2). mem_we_n stays 1 and mem_dqm_n stays 2'b00.
- R4: With page reads on, a word whose address is not the start of a page follows the previous word by pdel+1 cycles. The address is one higher than before, and output enable stays low between the two words.
- R5: A page starts at an address with addr[1:0]=0 when the page-size bit is 0 (4 words), or with addr[2:0]=0 when it is 1 (8 words). A word at a page start takes a full access: output enable is high for setup+1 cycles, then low for strobe+1 cycles, and there is no hold.
- R6: With page reads off, each following word comes after hold+1 cycles with output enable high, then setup+1 and strobe+1 cycles. Chip select stays low throughout.
- R7: After the last word there are hold+1 cycles with chip select low and output enable high. After that the block is idle with mem_cs_n=3'b111.
- R8: A request is refused when it has page reads on together with extended-wait or select-strobe set for its chip select, or names chip select 3, or asks for zero words. In that case req_reject is high for one cycle after the request edge and no chip select is asserted. When page reads are off, the extended-wait and select-strobe bits have no effect.
- R9: A burst returns exactly req_count words. Word i carries the data bus value sampled while the address is req_addr+i, in the last cycle of its strobe or page-delay phase.
- R10: While busy, req_valid and the request fields are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when idle |
| req_cs | input | 2 | Chip select index 0..2 |
| req_addr | input | AW | First word address |
| req_count | input | CW | Number of words |
| cfg_page_en | input | 3 | Page-read enable per chip select |
| cfg_page8 | input | 3 | Page size per chip select: 0 = 4 words, 1 = 8 words |
| cfg_ext_wait | input | 3 | Extended-wait option per chip select |
| cfg_sel_strobe | input | 3 | Select-strobe option per chip select |
| cfg_setup | input | 3*TW | Setup count per chip select |
| cfg_strobe | input | 3*TW | Strobe count per chip select |
| cfg_hold | input | 3*TW | Hold count per chip select |
| cfg_pdel | input | 3*TW | Page delay per chip select |
| busy | output | 1 | Burst in progress |
| req_reject | output | 1 | One-cycle pulse for a refused request |
| mem_cs_n | output | 3 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable, always inactive |
| mem_dqm_n | output | 2 | Active-low byte mask |
| mem_addr | output | AW | Word address |
| mem_data | input | 16 | External data bus |
| rd_data | output | 16 | Captured word |
| rd_valid | output | 1 | rd_data valid for one cycle |

## Verification
Two things can land in the same cycle: the capture of a word, and the decision on what the next word needs, either a page-delay step or a full access at a page boundary. The bench sweeps start addresses 0..7 with several burst lengths for both page sizes, so boundaries fall at every offset inside a burst, including the first follow-on word. At each capture cycle it checks the output enable level against the arithmetic rule for the next address, and it checks that the next valid strobe comes at the cycle predicted by that rule. A second clash, a new request arriving while a burst runs, is provoked by holding req_valid high with different fields during every burst and counting the words returned.

// File: rtl/norpg_pkg.sv
package norpg_pkg;

    localparam int NCS = 3;
    localparam int CSW = 2;
    localparam int TW  = 4;
    localparam int DW  = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_PAGE,
        ST_HOLD
    } norpg_state_e;

    typedef struct packed {
        logic          page_en;
        logic          page8;
        logic [TW-1:0] setup;
        logic [TW-1:0] strobe;
        logic [TW-1:0] hold;
        logic [TW-1:0] pdel;
    } cs_cfg_t;

    function automatic logic page_start(input logic [2:0] lo, input logic page8);
        return page8 ? (lo == 3'd0) : (lo[1:0] == 2'd0);
    endfunction

endpackage

// File: rtl/norpg_cfg_sel.sv
module norpg_cfg_sel
    import norpg_pkg::*;
(
    input  logic [CSW-1:0]    cs,
    input  logic [NCS-1:0]    page_en,
    input  logic [NCS-1:0]    page8,
    input  logic [NCS-1:0]    ext_wait,
    input  logic [NCS-1:0]    sel_strobe,
    input  logic [NCS*TW-1:0] setup,
    input  logic [NCS*TW-1:0] strobe,
    input  logic [NCS*TW-1:0] hold,
    input  logic [NCS*TW-1:0] pdel,
    output cs_cfg_t           cfg,
    output logic              illegal
);

    cs_cfg_t  tbl [NCS];
    logic [NCS-1:0] mode_clash;

    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign tbl[g] = '{
            page_en: page_en[g],
            page8:   page8[g],
            setup:   setup[g*TW +: TW],
            strobe:  strobe[g*TW +: TW],
            hold:    hold[g*TW +: TW],
            pdel:    pdel[g*TW +: TW]
        };
        assign mode_clash[g] = page_en[g] && (ext_wait[g] || sel_strobe[g]);
    end

    always_comb begin
        cfg     = '0;
        illegal = 1'b1;
        for (int i = 0; i < NCS; i++) begin
            if (cs == CSW'(i)) begin
                cfg     = tbl[i];
                illegal = mode_clash[i];
            end
        end
    end

endmodule

// File: rtl/norpg_addr_gen.sv
module norpg_addr_gen
    import norpg_pkg::*;
#(
    parameter int AW = 20,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    input  logic [CW-1:0] count_in,
    input  logic          step,
    input  logic          page8,
    output logic [AW-1:0] addr,
    output logic          last,
    output logic          next_page_start
);

    logic [AW-1:0] addr_q;
    logic [CW-1:0] remain_q;
    logic [2:0]    lo_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            remain_q <= '0;
        end else if (load) begin
            addr_q   <= addr_in;
            remain_q <= count_in;
        end else if (step) begin
            addr_q   <= addr_q + AW'(1);
            remain_q <= remain_q - CW'(1);
        end
    end

    assign lo_next         = addr_q[2:0] + 3'd1;
    assign next_page_start = page_start(lo_next, page8);
    assign last            = (remain_q == CW'(1));
    assign addr            = addr_q;

    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
        step |-> (remain_q > CW'(1)));

endmodule

// File: rtl/norpg_capture.sv
module norpg_capture
    import norpg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= take;
            if (take) dout <= din;
        end
    end

endmodule

// File: rtl/norpg_read_seq.sv
module norpg_read_seq
    import norpg_pkg::*;
#(
    parameter int AW = 20,
    parameter int CW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [CSW-1:0]    req_cs,
    input  logic [AW-1:0]     req_addr,
    input  logic [CW-1:0]     req_count,
    input  logic [NCS-1:0]    cfg_page_en,
    input  logic [NCS-1:0]    cfg_page8,
    input  logic [NCS-1:0]    cfg_ext_wait,
    input  logic [NCS-1:0]    cfg_sel_strobe,
    input  logic [NCS*TW-1:0] cfg_setup,
    input  logic [NCS*TW-1:0] cfg_strobe,
    input  logic [NCS*TW-1:0] cfg_hold,
    input  logic [NCS*TW-1:0] cfg_pdel,
    output logic              busy,
    output logic              req_reject,
    output logic [NCS-1:0]    mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [1:0]        mem_dqm_n,
    output logic [AW-1:0]     mem_addr,
    input  logic [DW-1:0]     mem_data,
    output logic [DW-1:0]     rd_data,
    output logic              rd_valid
);

    norpg_state_e   state;
    logic [TW-1:0]  cnt;
    logic [TW-1:0]  lim;
    logic           at_lim;
    logic [CSW-1:0] cs_q;
    cs_cfg_t        cfg_q;
    cs_cfg_t        sel_cfg;
    logic           sel_illegal;
    logic           bad_req;
    logic           fin_q;
    logic           reject_q;
    logic           load, take, step, last, next_ps;

    norpg_cfg_sel i_cfg_sel (
        .cs         (req_cs),
        .page_en    (cfg_page_en),
        .page8      (cfg_page8),
        .ext_wait   (cfg_ext_wait),
        .sel_strobe (cfg_sel_strobe),
        .setup      (cfg_setup),
        .strobe     (cfg_strobe),
        .hold       (cfg_hold),
        .pdel       (cfg_pdel),
        .cfg        (sel_cfg),
        .illegal    (sel_illegal)
    );

    assign bad_req = sel_illegal || (req_count == '0);
    assign load    = (state == ST_IDLE) && req_valid && !bad_req;

    always_comb begin
        case (state)
            ST_SETUP:  lim = cfg_q.setup;
            ST_STROBE: lim = cfg_q.strobe;
            ST_PAGE:   lim = cfg_q.pdel;
            ST_HOLD:   lim = cfg_q.hold;
            default:   lim = '0;
        endcase
    end

    assign at_lim = (cnt == lim);
    assign take   = ((state == ST_STROBE) || (state == ST_PAGE)) && at_lim;
    assign step   = take && !last;

    norpg_addr_gen #(.AW(AW), .CW(CW)) i_addr_gen (
        .clk             (clk),
        .rst             (rst),
        .load            (load),
        .addr_in         (req_addr),
        .count_in        (req_count),
        .step            (step),
        .page8           (cfg_q.page8),
        .addr            (mem_addr),
        .last            (last),
        .next_page_start (next_ps)
    );

    norpg_capture i_capture (
        .clk   (clk),
        .rst   (rst),
        .take  (take),
        .din   (mem_data),
        .dout  (rd_data),
        .valid (rd_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            cs_q     <= '0;
            cfg_q    <= '0;
            fin_q    <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            reject_q <= 1'b0;
            cnt      <= cnt + TW'(1);
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (req_valid) begin
                        if (bad_req) begin
                            reject_q <= 1'b1;
                        end else begin
                            state <= ST_SETUP;
                            cs_q  <= req_cs;
                            cfg_q <= sel_cfg;
                            fin_q <= 1'b0;
                        end
                    end
                end
                ST_SETUP: begin
                    if (at_lim) begin
                        state <= ST_STROBE;
                        cnt   <= '0;
                    end
                end
                ST_STROBE, ST_PAGE: begin
                    if (at_lim) begin
                        cnt <= '0;
                        if (last) begin
                            state <= ST_HOLD;
                            fin_q <= 1'b1;
                        end else if (cfg_q.page_en) begin
                            state <= next_ps ? ST_SETUP : ST_PAGE;
                        end else begin
                            state <= ST_HOLD;
                        end
                    end
                end
                ST_HOLD: begin
                    if (at_lim) begin
                        cnt   <= '0;
                        state <= fin_q ? ST_IDLE : ST_SETUP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state != ST_IDLE);
    assign req_reject = reject_q;
    assign mem_cs_n   = busy ? ~(NCS'(1) << cs_q) : '1;
    assign mem_oe_n   = !((state == ST_STROBE) || (state == ST_PAGE));
    assign mem_we_n   = 1'b1;
    assign mem_dqm_n  = busy ? 2'b00 : 2'b11;

    assert_cs_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_cs_n));

    assert_cs_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mem_cs_n));

    assert_oe_within_cs_R4: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_cs_n != '1));

    assert_page_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PAGE && cnt == '0) |-> (mem_addr == $past(mem_addr) + AW'(1)));

    assert_reject_idle_R8: assert property (@(posedge clk) disable iff (rst)
        req_reject |-> !busy);

    assert_valid_source_R9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(state == ST_STROBE || state == ST_PAGE));

endmodule

// File: tb/test_norpg_read_seq.sv
module test_norpg_read_seq;

    localparam int AW = 20;
    localparam int CW = 8;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_cs = '0;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_count = '0;
    logic [2:0]    cfg_page_en = '0, cfg_page8 = '0, cfg_ext_wait = '0, cfg_sel_strobe = '0;
    logic [3*TW-1:0] cfg_setup, cfg_strobe, cfg_hold, cfg_pdel;
    logic          busy, req_reject, mem_oe_n, mem_we_n, rd_valid;
    logic [2:0]    mem_cs_n;
    logic [1:0]    mem_dqm_n;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_data, rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    int sv[3] = '{0, 2, 1};
    int tv[3] = '{0, 3, 2};
    int hv[3] = '{0, 1, 3};
    int pv[3] = '{0, 1, 2};

    always #2.5 clk = ~clk;

    assign mem_data = mem_addr[15:0] ^ 16'h5A3C;

    norpg_read_seq #(.AW(AW), .CW(CW)) i_norpg_read_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cs(req_cs),
        .req_addr(req_addr), .req_count(req_count),
        .cfg_page_en(cfg_page_en), .cfg_page8(cfg_page8),
        .cfg_ext_wait(cfg_ext_wait), .cfg_sel_strobe(cfg_sel_strobe),
        .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe),
        .cfg_hold(cfg_hold), .cfg_pdel(cfg_pdel),
        .busy(busy), .req_reject(req_reject), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dqm_n(mem_dqm_n),
        .mem_addr(mem_addr), .mem_data(mem_data),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            chk(1'b0, "R1", "watchdog expired", cycles, 190000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic run_burst(input int cs, input int a0, input int cnt);
        int s = sv[cs], st = tv[cs], h = hv[cs], p = pv[cs];
        bit pe = cfg_page_en[cs];
        int psz = cfg_page8[cs] ? 8 : 4;
        int t = 0, w = 0, nt, lt = -1;
        bit cs_bad = 1'b0, done = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_cs = 2'(cs); req_addr = AW'(a0); req_count = CW'(cnt);
        @(posedge clk);
        nt = s + st + 2;
        while (!done) begin
            @(negedge clk);
            if (t == 0) begin
                // R10: keep a different request pending for the whole burst
                req_cs = 2'((cs + 1) % 3); req_addr = '1; req_count = CW'(3);
            end
            if (w < cnt) begin
                if (t == nt - 1) begin
                    chk(mem_oe_n == 1'b0, "R2", "oe low before capture", mem_oe_n, 0);
                    chk(mem_addr == AW'(a0 + w), "R9", "address of word", mem_addr, a0 + w);
                end
                if (rd_valid != (t == nt)) begin
                    chk(1'b0, "R2", "rd_valid timing", rd_valid, (t == nt));
                    done = 1'b1;
                end else if (t == nt) begin
                    chk(rd_data == 16'((a0 + w) ^ 'h5A3C), "R9", "data word",
                        rd_data, 16'((a0 + w) ^ 'h5A3C));
                    w++;
                    if (w < cnt) begin
                        int a = a0 + w;
                        bit cont = pe && ((a % psz) != 0);
                        chk(mem_oe_n == !cont, cont ? "R4" : (pe ? "R5" : "R6"),
                            "oe after capture", mem_oe_n, !cont);
                        nt = t + (cont ? p + 1 : (pe ? s + st + 2 : h + 1 + s + st + 2));
                    end else begin
                        lt = t;
                        req_valid = 1'b0;
                        chk(mem_oe_n == 1'b1, "R7", "oe high in final hold", mem_oe_n, 1);
                    end
                end
            end else if (rd_valid) begin
                chk(1'b0, "R10", "extra word returned", 1, 0);
                done = 1'b1;
            end
            if (lt >= 0 && t == lt + h)
                chk(busy == 1'b1, "R7", "busy in last hold cycle", busy, 1);
            if (lt >= 0 && t == lt + h + 1) begin
                chk(busy == 1'b0 && mem_cs_n == 3'b111, "R7", "idle after hold",
                    {busy, mem_cs_n}, 4'b0111);
                done = 1'b1;
            end else if (!done) begin
                if (mem_cs_n != 3'(~(1 << cs)) || !mem_we_n || mem_dqm_n != 2'b00)
                    cs_bad = 1'b1;
            end
            if (t > 3000) begin
                chk(1'b0, "R2", "burst timeout", t, 0);
                done = 1'b1;
            end
            if (!done) begin
                @(posedge clk);
                t++;
            end
        end
        req_valid = 1'b0;
        chk(!cs_bad, "R3", "chip select/we/mask during burst", cs_bad, 0);
        while (busy) @(posedge clk);
    endtask

    task automatic try_req(input int cs, input int cnt, input bit exp_rej, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_cs = 2'(cs); req_addr = AW'(5); req_count = CW'(cnt);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_reject == exp_rej, tag, "reject pulse", req_reject, exp_rej);
        chk(busy == !exp_rej, tag, "busy after request", busy, !exp_rej);
        if (exp_rej) begin
            chk(mem_cs_n == 3'b111, tag, "no chip select on refusal", mem_cs_n, 7);
            @(negedge clk);
            chk(req_reject == 1'b0, tag, "reject lasts one cycle", req_reject, 0);
        end
        while (busy) @(posedge clk);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            cfg_setup[i*TW +: TW]  = TW'(sv[i]);
            cfg_strobe[i*TW +: TW] = TW'(tv[i]);
            cfg_hold[i*TW +: TW]   = TW'(hv[i]);
            cfg_pdel[i*TW +: TW]   = TW'(pv[i]);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(busy == 0 && mem_cs_n == 3'b111 && mem_oe_n && mem_we_n && mem_dqm_n == 2'b11
            && !rd_valid && !req_reject, "R1", "outputs in reset",
            {busy, mem_cs_n, mem_oe_n, mem_we_n, mem_dqm_n, rd_valid, req_reject}, 10'b0111111100);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && mem_cs_n == 3'b111, "R1", "idle after reset", {busy, mem_cs_n}, 4'b0111);

        // Sweep: chip select x mode (off, 4-word page, 8-word page) x start x length
        for (int cs = 0; cs < 3; cs++) begin
            for (int mode = 0; mode < 3; mode++) begin
                cfg_page_en[cs] = (mode != 0);
                cfg_page8[cs]   = (mode == 2);
                for (int a0 = 0; a0 < 8; a0++) begin
                    foreach (sv[k]) begin
                        int cnt = (k == 0) ? 1 : ((k == 1) ? 4 : 9);
                        run_burst(cs, a0, cnt);
                    end
                end
            end
        end

        // R8: refusals and ignored options
        cfg_page_en = 3'b111;
        cfg_ext_wait = 3'b010;
        try_req(1, 2, 1'b1, "R8");
        cfg_ext_wait = '0;
        cfg_sel_strobe = 3'b100;
        try_req(2, 2, 1'b1, "R8");
        cfg_sel_strobe = '0;
        try_req(3, 2, 1'b1, "R8");
        try_req(0, 0, 1'b1, "R8");
        cfg_page_en = 3'b101;
        cfg_ext_wait = 3'b010;
        cfg_sel_strobe = 3'b010;
        try_req(1, 2, 1'b0, "R8");
        cfg_ext_wait = '0;
        cfg_sel_strobe = '0;
        run_burst(1, 6, 3);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule